// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Device Model

This block is synthesizable control and storage logic that behaves like a 65,536 x 1 dynamic memory seen from its pins. A controller drives active-low row strobe, column strobe and write strobe, plus an 8-bit address bus that carries the row half and then the column half of a 16-bit cell index. The block samples those strobes in a much faster system clock. A 1-bit data output and its output enable model the three-state data pin. Analog retention is not modelled, and no timing limit is checked.

Each strobe passes through a two-flop synchronizer and an edge detector. On a detected edge, the address and data inputs are sampled in that same clock cycle. The write strobe and the column strobe are two separate edges. Whichever of them falls last decides when write data is taken. The output-enable rules keep read data on the pin for as long as the column strobe stays low. This holds across the row strobe rising and across a refresh row cycle placed underneath it.

Top module: `dram_core`

## Requirements
- R1: A row strobe fall captures `addr` as the row. A later column strobe fall, with the row strobe low, captures `addr` as the column. The accessed cell index is {row, column}, with the row in bits 15..8. Outputs respond within three clock cycles of a strobe edge at the pins.
- R2: If the write strobe is already low when the column strobe falls (early write), `din` is written to the cell. `doutEn` stays 0 for the whole cycle.
- R3: If the write strobe is high when the column strobe falls, `doutEn` becomes 1 and `dout` shows the stored bit. Read data has the same polarity as the data that was written.
- R4: If the write strobe falls after the column strobe, while both the row and column strobes are low, `din` is written to the cell of that access. `dout` keeps showing the old value that was read.
- R5: `doutEn` is 0 whenever the column strobe is high. Once it is set, it stays 1 with a stable `dout` until the column strobe rises, even if the row strobe rises first.
- R6: While the row strobe stays low, each new column strobe fall opens a new access in the same row. Reads, early writes and delayed writes may be mixed freely within the row.
- R7: A row strobe cycle with the column strobe held high leaves `doutEn` at 0 and leaves every cell unchanged.
- R8: If the column strobe is already low when the row strobe falls (hidden refresh), `doutEn` and `dout` keep the previously read data. A column strobe rise during that cycle sets `doutEn` to 0.
- R9: A write strobe fall and a column strobe fall detected in the same clock cycle count as an early write. The bit is written and `doutEn` stays 0.
- R10: After reset, `doutEn` is 0 and every cell reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rstN | input | 1 | Active-low reset of the logic and the array |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| addr | input | 8 | Multiplexed row/column address |
| din | input | 1 | Write data |
| dout | output | 1 | Read data |
| doutEn | output | 1 | Output enable of the data pin (0 = high impedance) |

## Verification
Two functions can fall in the same cycle: the column strobe fall that opens an access, and the write strobe fall that would make the access a delayed write. The bench provokes this by lowering both strobes on the same clock edge. Because both pass through identical synchronizers, both edges are detected in one cycle. The result is judged an early write: the output enable must stay 0 for the whole cycle, and a later read must return the written bit.

// File: rtl/dram_pkg.sv
package dram_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic latchRow;  // capture row half
    logic latchCol;  // capture column half
    logic earlyWr;   // write din at column capture
    logic readOut;   // load read data and enable output
    logic lateWr;    // write din to the open access
    logic outOff;    // release the output
  } ctlStrobe_t;
endpackage

// File: rtl/dram_sync.sv
module dram_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawN,
  output logic [WIDTH-1:0] lvlN,
  output logic [WIDTH-1:0] fell,
  output logic [WIDTH-1:0] rose
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_ch
      logic [STAGES:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-1:0], rawN[i]};
      end
      assign lvlN[i] = pipe[STAGES-1];
      assign fell[i] = !pipe[STAGES-1] && pipe[STAGES];
      assign rose[i] = pipe[STAGES-1] && !pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  output ctlStrobe_t stb
);
  localparam int CH = 3;
  logic [CH-1:0] lvlN, fell, rose;
  logic rasLow, casLvl, weLvl, rasFell, casFell, casRose, weFell;
  logic casAcc, accessOpen;

  dram_sync #(.WIDTH(CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .rawN({weN, casN, rasN}),
    .lvlN(lvlN), .fell(fell), .rose(rose)
  );

  assign rasLow  = !lvlN[0];
  assign casLvl  = lvlN[1];
  assign weLvl   = lvlN[2];
  assign rasFell = fell[0];
  assign casFell = fell[1];
  assign casRose = rose[1];
  assign weFell  = fell[2];

  // a column fall under a low row strobe is always an access
  assign casAcc = casFell && rasLow;

  always_comb begin
    stb          = '0;
    stb.latchRow = rasFell;
    stb.latchCol = casAcc;
    stb.earlyWr  = casAcc && !weLvl;
    stb.readOut  = casAcc && weLvl;
    stb.lateWr   = weFell && rasLow && !casLvl && accessOpen && !casAcc;
    stb.outOff   = casRose;
  end

  // a read access that a later write strobe fall may still turn into a write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              accessOpen <= 1'b0;
    else if (stb.readOut)                   accessOpen <= 1'b1;
    else if (casRose || rasFell || stb.lateWr) accessOpen <= 1'b0;
  end
endmodule

// File: rtl/dram_dpath.sv
module dram_dpath
  import dram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              doutEn
);
  localparam int IDX_W = 2 * ADDR_W;
  localparam int CELLS = 1 << IDX_W;

  logic [CELLS-1:0]  cellBits;
  logic [ADDR_W-1:0] rowQ, colQ;
  logic [IDX_W-1:0]  newIdx, openIdx;

  assign newIdx  = {rowQ, addr};
  assign openIdx = {rowQ, colQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellBits <= '0;
      rowQ     <= '0;
      colQ     <= '0;
      dout     <= 1'b0;
      doutEn   <= 1'b0;
    end else begin
      if (stb.latchRow) rowQ <= addr;
      if (stb.latchCol) colQ <= addr;
      if (stb.earlyWr)  cellBits[newIdx]  <= din;
      if (stb.lateWr)   cellBits[openIdx] <= din;
      if (stb.readOut) begin
        dout   <= cellBits[newIdx];
        doutEn <= 1'b1;
      end else if (stb.outOff) begin
        doutEn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dram_core.sv
module dram_core
  import dram_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              doutEn
);
  ctlStrobe_t stb;

  dram_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .stb(stb)
  );

  dram_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .din(din),
    .dout(dout), .doutEn(doutEn)
  );
endmodule

// File: rtl/dram_core_chk.sv
module dram_core_chk (
  input logic clk,
  input logic rstN,
  input logic casN,
  input logic weN,
  input logic dout,
  input logic doutEn
);
  // the enable only turns on after a column strobe fall (R5)
  p_en_needs_cas_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn) |-> !$past(casN, 3));

  // the enable only turns off after a column strobe rise (R5)
  p_off_needs_cas_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doutEn) |-> $past(casN, 3));

  // an access with the write strobe low never enables the output (R2)
  p_early_write_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn) |-> $past(weN, 3));

  // read data holds while the output stays enabled (R3)
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doutEn && $past(doutEn)) |-> $stable(dout));
endmodule

bind dram_core dram_core_chk u_chk (
  .clk(clk), .rstN(rstN), .casN(casN), .weN(weN), .dout(dout), .doutEn(doutEn)
);

// File: tb/sim_dram_core.sv
`timescale 1ns/1ps
module sim_dram_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [7:0] addr = '0;
  logic din = 1'b0;
  logic dout, doutEn;

  int nChecks = 0;
  int nFails  = 0;
  bit mdl [int];

  always #4 clk = ~clk;

  dram_core u0 (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .din(din), .dout(dout), .doutEn(doutEn)
  );

  function automatic bit mget(int idx);
    return mdl.exists(idx) ? mdl[idx] : 1'b0;
  endfunction

  function automatic int cellOf(logic [7:0] r, logic [7:0] c);
    return int'({r, c});
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic openRow(logic [7:0] r);
    addr = r; rasN = 1'b0; tick(5);
  endtask

  task automatic closeRow();
    rasN = 1'b1; tick(5);
  endtask

  task automatic casRead(logic [7:0] r, logic [7:0] c, string req);
    bit e;
    e = mget(cellOf(r, c));
    addr = c; weN = 1'b1; casN = 1'b0; tick(5);
    chk(doutEn === 1'b1, req, int'(doutEn), 1);
    chk(dout === e, req, int'(dout), int'(e));
    casN = 1'b1; tick(5);
    chk(doutEn === 1'b0, "R5", int'(doutEn), 0);
  endtask

  task automatic casEarly(logic [7:0] r, logic [7:0] c, bit d);
    din = d; weN = 1'b0; tick(5);
    addr = c; casN = 1'b0; tick(5);
    chk(doutEn === 1'b0, "R2", int'(doutEn), 0);
    casN = 1'b1; weN = 1'b1; tick(5);
    mdl[cellOf(r, c)] = d;
  endtask

  task automatic casRmw(logic [7:0] r, logic [7:0] c, bit d);
    bit old;
    old = mget(cellOf(r, c));
    addr = c; weN = 1'b1; casN = 1'b0; tick(5);
    chk(dout === old && doutEn === 1'b1, "R3", int'(dout), int'(old));
    din = d; weN = 1'b0; tick(5);
    chk(doutEn === 1'b1 && dout === old, "R4", int'(dout), int'(old));
    casN = 1'b1; weN = 1'b1; tick(5);
    mdl[cellOf(r, c)] = d;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r, c;
    void'($urandom(32'h5eed_2024));
    tick(4);
    chk(doutEn === 1'b0, "R10", int'(doutEn), 0);
    rstN = 1'b1; tick(4);
    chk(doutEn === 1'b0, "R10", int'(doutEn), 0);

    // R10: an untouched cell reads zero
    openRow(8'hA5); casRead(8'hA5, 8'h3C, "R10"); closeRow();

    // R1 / R3 polarity: row and column halves address distinct cells
    openRow(8'h12); casEarly(8'h12, 8'h34, 1'b1); closeRow();
    openRow(8'h34); casEarly(8'h34, 8'h12, 1'b0); closeRow();
    openRow(8'h12); casRead(8'h12, 8'h34, "R1"); closeRow();
    openRow(8'h34); casRead(8'h34, 8'h12, "R3"); closeRow();

    // R4: delayed write flips a bit, old value shown, new one read back
    openRow(8'h12); casRmw(8'h12, 8'h34, 1'b0); casRead(8'h12, 8'h34, "R4"); closeRow();

    // R6: page mode, mixed accesses in one row including the page edges
    openRow(8'h77);
    casEarly(8'h77, 8'h00, 1'b1);
    casEarly(8'h77, 8'hFF, 1'b1);
    casRmw(8'h77, 8'h00, 1'b0);
    casRead(8'h77, 8'hFF, "R6");
    casRead(8'h77, 8'h00, "R6");
    closeRow();

    // R9: write strobe and column strobe fall together
    openRow(8'hC3);
    din = 1'b1; addr = 8'h5A; weN = 1'b0; casN = 1'b0; tick(5);
    chk(doutEn === 1'b0, "R9", int'(doutEn), 0);
    casN = 1'b1; weN = 1'b1; tick(5);
    mdl[cellOf(8'hC3, 8'h5A)] = 1'b1;
    casRead(8'hC3, 8'h5A, "R9");
    closeRow();

    // R7: row-only refresh cycle keeps output off and data intact
    addr = 8'h12; rasN = 1'b0; tick(5);
    chk(doutEn === 1'b0, "R7", int'(doutEn), 0);
    rasN = 1'b1; tick(5);
    chk(doutEn === 1'b0, "R7", int'(doutEn), 0);
    openRow(8'h77); casRead(8'h77, 8'hFF, "R7"); closeRow();

    // R5 / R8: hidden refresh under a held read
    openRow(8'h77);
    addr = 8'hFF; weN = 1'b1; casN = 1'b0; tick(5);
    rasN = 1'b1; tick(5);
    chk(doutEn === 1'b1 && dout === 1'b1, "R5", int'(dout), 1);
    addr = 8'h09; rasN = 1'b0; tick(5);
    chk(doutEn === 1'b1 && dout === 1'b1, "R8", int'(dout), 1);
    rasN = 1'b1; tick(5);
    chk(doutEn === 1'b1 && dout === 1'b1, "R8", int'(dout), 1);
    addr = 8'h0A; rasN = 1'b0; tick(5);
    casN = 1'b1; tick(5);
    chk(doutEn === 1'b0, "R8", int'(doutEn), 0);
    rasN = 1'b1; tick(5);
    chk(doutEn === 1'b0, "R8", int'(doutEn), 0);

    // random sessions across rows
    for (int s = 0; s < 80; s++) begin
      r = 8'($urandom_range(0, 255));
      openRow(r);
      for (int k = 0; k < 4; k++) begin
        c = 8'($urandom_range(0, 255));
        case ($urandom_range(0, 2))
          0: casRead(r, c, "R6");
          1: casEarly(r, c, 1'($urandom_range(0, 1)));
          default: casRmw(r, c, 1'($urandom_range(0, 1)));
        endcase
      end
      closeRow();
    end

    summary();
    $finish;
  end
endmodule